// File: doc/BRIEF.md
# Asynchronous Memory Write Strobe Controller

This block turns write and read commands from a core into strobe cycles on an external asynchronous memory bus. Each access drives one active-low bank select, an address, a data bus with an output enable, and an active-low write or read strobe. All bus timing is counted in cycles of the interface clock. Two settings shape the timing: a wait count, which sets how long the strobe stays low, and a hold count, which sets how long address and data stay on the bus after the strobe rises.

The core hands over one command at a time through a valid/ready handshake. The wait and hold counts are captured together with the command. The acknowledge-mode input is live, not captured. When that mode is on, the external device can hold the strobe low by pulling its acknowledge line low. The controller spaces accesses so that the bus recovers between them. When a read follows a write directly, the controller adds one turnaround cycle, so the write data bus is released well before the read strobe falls.

Top module: `amw_write_ctrl`

## Requirements
- R1: While rst_n is low, and in the cycle after it was low, mem_wr_n and mem_rd_n are 1, every mem_sel_n bit is 1, mem_wdata_oe is 0 and cmd_ready is 1. This holds even when reset arrives in the middle of an access.
- R2: For an access to bank k, only mem_sel_n[k] goes low. It falls exactly one clock before the strobe falls. The command's address and write data are on the bus from that select cycle onward.
- R3: When acknowledge is ignored or held high, the strobe stays low for exactly W clocks. W is the wait count captured with the command. A wait count of 0 behaves as 1.
- R4: During a write, mem_wdata_oe is 1 and the write data is stable for 1 + W clocks before the strobe rises, and for 1 + W + S clocks when S acknowledge-low cycles stretch the strobe.
- R5: After the strobe rises, the select, the address and (for writes) the data and output enable stay unchanged for exactly H clocks. H is the captured hold count. In the next clock the select rises and mem_wdata_oe drops together.
- R6: When a write command is already waiting, the next write strobe falls exactly H + 2 clocks after the previous write strobe rose. This meets the minimum of 1 + H, for the same bank and for different banks.
- R7: When a read command is already waiting after a write, the read strobe falls exactly H + 3 clocks after the write strobe rose. The two strobes are never low together.
- R8: The write data bus is released for at least two clocks before any read strobe falls.
- R9: With cfg_ack_en = 1, every cycle of the strobe in which mem_ack is 0 adds one clock to the strobe width. The wait countdown only moves in cycles where mem_ack is 1.
- R10: With cfg_ack_en = 0, mem_ack has no effect, and the strobe width is W even while mem_ack is held low.
- R11: The wait and hold counts are captured when a command is accepted. Changes to cfg_wait and cfg_hold during the access do not change that access.
- R12: cmd_ready is 0 from the clock after acceptance until the access's hold cycles are over. It is never 1 while a strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Controller can accept a command |
| cmd_is_read | input | 1 | 1 = read access, 0 = write access |
| cmd_bank | input | BANK_W | Bank index to select |
| cmd_addr | input | ADDR_W | Access address |
| cmd_data | input | DATA_W | Write data |
| cfg_wait | input | CNT_W | Strobe wait count (0 behaves as 1) |
| cfg_hold | input | CNT_W | Hold count after strobe rise |
| cfg_ack_en | input | 1 | 1 = honour mem_ack, 0 = ignore it |
| mem_ack | input | 1 | Device acknowledge, low stretches the strobe |
| mem_sel_n | output | NBANK | Bank selects, active low |
| mem_addr | output | ADDR_W | Bus address |
| mem_wdata | output | DATA_W | Bus write data |
| mem_wdata_oe | output | 1 | Write data output enable |
| mem_wr_n | output | 1 | Write strobe, active low |
| mem_rd_n | output | 1 | Read strobe, active low |

## Verification
On every clock, the bound checker enforces the following:
- at most one bank selected at a time;
- a select already low in the cycle before any write strobe falls;
- write data enabled for the whole write strobe;
- the two strobes never overlapping;
- the data bus off for the read strobe and the cycle before it;
- ready low during strobes;
- the strobe held low while an honoured acknowledge is low.

The exact counts need the bench's scoreboard scenarios. These are the strobe width for each wait setting, the stretch from acknowledge, the data-setup length, the hold length, and the exact write-to-write and write-to-read gaps. The same goes for capture of the counts at acceptance and for reset in the middle of an access.

// File: rtl/amw_pkg.sv
// Package: shared types for the asynchronous memory write strobe controller.
// Assumes: the sequencer and the bus driver decode the same state encoding.
package amw_pkg;

    // Access phases of one bus cycle
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,   // bus quiet, ready for a command
        ST_TURN   = 3'd1,   // write-to-read turnaround spacer
        ST_SETUP  = 3'd2,   // select and address out, strobe high
        ST_STROBE = 3'd3,   // strobe low, wait countdown running
        ST_HOLD   = 3'd4    // strobe high, address/data held
    } amw_state_e;

endpackage

// File: rtl/amw_cmd_reg.sv
// Module: amw_cmd_reg
// Captures the command and its timing counts on the accept handshake.
// Stores the wait count minus one, with a zero wait count treated as one.
// Assumes: accept is a single-cycle pulse that comes only while idle.
module amw_cmd_reg #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int BANK_W = 2,
    parameter int CNT_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              in_is_read,
    input  logic [BANK_W-1:0] in_bank,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [DATA_W-1:0] in_data,
    input  logic [CNT_W-1:0]  in_wait,
    input  logic [CNT_W-1:0]  in_hold,
    output logic              lat_is_read,
    output logic [BANK_W-1:0] lat_bank,
    output logic [ADDR_W-1:0] lat_addr,
    output logic [DATA_W-1:0] lat_data,
    output logic [CNT_W-1:0]  lat_wait_m1,
    output logic [CNT_W-1:0]  lat_hold
);

    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] wait_m1_d;

    // Effective wait minus one (wait of 0 acts as 1)
    always_comb begin
        wait_m1_d = (in_wait == '0) ? '0 : (in_wait - ONE);
    end

    // Command and count capture on acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_is_read <= 1'b0;
            lat_bank    <= '0;
            lat_addr    <= '0;
            lat_data    <= '0;
            lat_wait_m1 <= '0;
            lat_hold    <= '0;
        end else if (accept) begin
            lat_is_read <= in_is_read;
            lat_bank    <= in_bank;
            lat_addr    <= in_addr;
            lat_data    <= in_data;
            lat_wait_m1 <= wait_m1_d;
            lat_hold    <= in_hold;
        end
    end

endmodule

// File: rtl/amw_cycle_timer.sv
// Module: amw_cycle_timer
// Loadable down-counter that times the strobe and hold phases.
// Assumes: load has priority over dec, and the counter is never decremented at zero.
module amw_cycle_timer #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             at_zero
);

    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt;

    // Counter update: load, count down, or hold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (dec) begin
            cnt <= cnt - ONE;
        end
    end

    // Terminal count flag
    always_comb begin
        at_zero = (cnt == '0);
    end

endmodule

// File: rtl/amw_seq_fsm.sv
// Module: amw_seq_fsm
// Sequences one access through setup, strobe and hold, and spaces accesses.
// A read taken in the first idle cycle after a write gets one turnaround cycle.
// The acknowledge only gates the countdown when ack_en is set.
// Assumes: timer at_zero reflects the value loaded in the previous cycle.
module amw_seq_fsm #(
    parameter int CNT_W = 5
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cmd_valid,
    input  logic                   cmd_is_read,
    input  logic                   lat_is_read,
    input  logic [CNT_W-1:0]       lat_wait_m1,
    input  logic [CNT_W-1:0]       lat_hold,
    input  logic                   ack_en,
    input  logic                   ack,
    input  logic                   t_zero,
    output amw_pkg::amw_state_e    state,
    output logic                   ready,
    output logic                   accept,
    output logic                   t_load,
    output logic [CNT_W-1:0]       t_load_val,
    output logic                   t_dec
);
    import amw_pkg::*;

    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    amw_state_e state_d;
    logic       wr_turn;
    logic       wr_turn_d;
    logic       ack_ok;

    // Handshake: ready only while idle
    always_comb begin
        ready  = (state == ST_IDLE);
        accept = ready && cmd_valid;
        ack_ok = !ack_en || ack;
    end

    // Next-state and timer control
    always_comb begin
        state_d    = state;
        t_load     = 1'b0;
        t_load_val = '0;
        t_dec      = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (accept) begin
                    state_d = (cmd_is_read && wr_turn) ? ST_TURN : ST_SETUP;
                end
            end
            ST_TURN: begin
                state_d = ST_SETUP;
            end
            ST_SETUP: begin
                state_d    = ST_STROBE;
                t_load     = 1'b1;
                t_load_val = lat_wait_m1;
            end
            ST_STROBE: begin
                if (ack_ok) begin
                    if (t_zero) begin
                        if (lat_hold == '0) begin
                            state_d = ST_IDLE;
                        end else begin
                            state_d    = ST_HOLD;
                            t_load     = 1'b1;
                            t_load_val = lat_hold - ONE;
                        end
                    end else begin
                        t_dec = 1'b1;
                    end
                end
            end
            ST_HOLD: begin
                if (t_zero) begin
                    state_d = ST_IDLE;
                end else begin
                    t_dec = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Marks the first idle cycle that follows a write
    always_comb begin
        wr_turn_d = (state != ST_IDLE) && (state_d == ST_IDLE) && !lat_is_read;
    end

    // State and turnaround flag registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            wr_turn <= 1'b0;
        end else begin
            state   <= state_d;
            wr_turn <= wr_turn_d;
        end
    end

endmodule

// File: rtl/amw_bus_drive.sv
// Module: amw_bus_drive
// Decodes the access phase into bank selects, strobes and data enable.
// Address and data come straight from the captured command.
// Assumes: the bank index is below NBANK and the phase encoding comes from amw_pkg.
module amw_bus_drive #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int NBANK  = 4,
    parameter int BANK_W = 2
) (
    input  amw_pkg::amw_state_e state,
    input  logic                lat_is_read,
    input  logic [BANK_W-1:0]   lat_bank,
    input  logic [ADDR_W-1:0]   lat_addr,
    input  logic [DATA_W-1:0]   lat_data,
    output logic [NBANK-1:0]    sel_n,
    output logic [ADDR_W-1:0]   addr,
    output logic [DATA_W-1:0]   wdata,
    output logic                wdata_oe,
    output logic                wr_n,
    output logic                rd_n
);
    import amw_pkg::*;

    logic bus_active;

    // Phase decode for strobes and data enable
    always_comb begin
        bus_active = (state == ST_SETUP) || (state == ST_STROBE) || (state == ST_HOLD);
        wdata_oe   = bus_active && !lat_is_read;
        wr_n       = !((state == ST_STROBE) && !lat_is_read);
        rd_n       = !((state == ST_STROBE) && lat_is_read);
        addr       = lat_addr;
        wdata      = lat_data;
    end

    // One active-low select per bank
    for (genvar b = 0; b < NBANK; b++) begin : g_sel
        assign sel_n[b] = !(bus_active && (lat_bank == BANK_W'(b)));
    end

endmodule

// File: rtl/amw_write_ctrl.sv
// Module: amw_write_ctrl (top)
// Asynchronous memory strobe controller: accepts one command at a time.
// Runs the select/strobe/hold sequence on the external bus with captured
// wait and hold counts and an optional acknowledge stretch.
// Assumes: cmd_bank < NBANK and the external acknowledge is synchronous to clk.
module amw_write_ctrl #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int NBANK  = 4,
    parameter int CNT_W  = 5,
    localparam int BANK_W = (NBANK > 1) ? $clog2(NBANK) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic              cmd_is_read,
    input  logic [BANK_W-1:0] cmd_bank,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_data,
    input  logic [CNT_W-1:0]  cfg_wait,
    input  logic [CNT_W-1:0]  cfg_hold,
    input  logic              cfg_ack_en,
    input  logic              mem_ack,
    output logic [NBANK-1:0]  mem_sel_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_wdata_oe,
    output logic              mem_wr_n,
    output logic              mem_rd_n
);
    import amw_pkg::*;

    amw_state_e        state;
    logic              accept;
    logic              lat_is_read;
    logic [BANK_W-1:0] lat_bank;
    logic [ADDR_W-1:0] lat_addr;
    logic [DATA_W-1:0] lat_data;
    logic [CNT_W-1:0]  lat_wait_m1;
    logic [CNT_W-1:0]  lat_hold;
    logic              t_load;
    logic [CNT_W-1:0]  t_load_val;
    logic              t_dec;
    logic              t_zero;

    amw_cmd_reg #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BANK_W(BANK_W), .CNT_W(CNT_W)
    ) u_cmd (
        .clk(clk), .rst_n(rst_n), .accept(accept),
        .in_is_read(cmd_is_read), .in_bank(cmd_bank), .in_addr(cmd_addr),
        .in_data(cmd_data), .in_wait(cfg_wait), .in_hold(cfg_hold),
        .lat_is_read(lat_is_read), .lat_bank(lat_bank), .lat_addr(lat_addr),
        .lat_data(lat_data), .lat_wait_m1(lat_wait_m1), .lat_hold(lat_hold)
    );

    amw_cycle_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_load_val),
        .dec(t_dec), .at_zero(t_zero)
    );

    amw_seq_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_is_read(cmd_is_read),
        .lat_is_read(lat_is_read), .lat_wait_m1(lat_wait_m1), .lat_hold(lat_hold),
        .ack_en(cfg_ack_en), .ack(mem_ack), .t_zero(t_zero), .state(state),
        .ready(cmd_ready), .accept(accept), .t_load(t_load),
        .t_load_val(t_load_val), .t_dec(t_dec)
    );

    amw_bus_drive #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NBANK(NBANK), .BANK_W(BANK_W)
    ) u_drive (
        .state(state), .lat_is_read(lat_is_read), .lat_bank(lat_bank),
        .lat_addr(lat_addr), .lat_data(lat_data), .sel_n(mem_sel_n),
        .addr(mem_addr), .wdata(mem_wdata), .wdata_oe(mem_wdata_oe),
        .wr_n(mem_wr_n), .rd_n(mem_rd_n)
    );

endmodule

// File: rtl/amw_write_ctrl_chk.sv
// Module: amw_write_ctrl_chk
// Cycle-level protocol checks on the controller's ports, bound to the top.
// Assumes: mem_ack and cfg_ack_en are driven synchronously to clk.
module amw_write_ctrl_chk #(
    parameter int NBANK = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_ready,
    input logic             cfg_ack_en,
    input logic             mem_ack,
    input logic [NBANK-1:0] mem_sel_n,
    input logic             mem_wdata_oe,
    input logic             mem_wr_n,
    input logic             mem_rd_n
);

    // R2
    single_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~mem_sel_n) <= 1);

    // R2
    sel_before_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_wr_n) |-> ($past(mem_sel_n) != {NBANK{1'b1}}));

    // R4
    oe_during_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_wr_n |-> mem_wdata_oe);

    // R7
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_wr_n && !mem_rd_n));

    // R8
    oe_off_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_rd_n) |-> (!mem_wdata_oe && !$past(mem_wdata_oe)));

    // R12
    busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_wr_n || !mem_rd_n) |-> !cmd_ready);

    // R9
    ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_wr_n && cfg_ack_en && !mem_ack) |=> !mem_wr_n);

endmodule

bind amw_write_ctrl amw_write_ctrl_chk #(.NBANK(NBANK)) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_ready(cmd_ready), .cfg_ack_en(cfg_ack_en),
    .mem_ack(mem_ack), .mem_sel_n(mem_sel_n), .mem_wdata_oe(mem_wdata_oe),
    .mem_wr_n(mem_wr_n), .mem_rd_n(mem_rd_n)
);

// File: tb/amw_write_ctrl_tb.sv
// Scoreboard bench: the driver queues expected access shapes, the monitor
// measures each access on the bus and compares.
module amw_write_ctrl_tb;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 16;
    localparam int NBANK  = 4;
    localparam int CNT_W  = 5;
    localparam int BANK_W = 2;

    typedef struct {
        bit              rd;
        int              bank;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        int              low;
        int              setup;
        int              hold;
        int              gap;
        int              stretch;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0, cmd_is_read = 1'b0;
    logic [BANK_W-1:0] cmd_bank = '0;
    logic [ADDR_W-1:0] cmd_addr = '0;
    logic [DATA_W-1:0] cmd_data = '0;
    logic [CNT_W-1:0] cfg_wait = '0, cfg_hold = '0;
    logic cfg_ack_en = 1'b0, mem_ack = 1'b1;
    logic cmd_ready, mem_wdata_oe, mem_wr_n, mem_rd_n;
    logic [NBANK-1:0] mem_sel_n;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_wdata;

    int checks = 0, errors = 0, cyc = 0;
    bit done = 0, mon_en = 1;
    exp_t q[$];
    bit prev_wr = 0;
    int prev_h = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    amw_write_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NBANK(NBANK), .CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_is_read(cmd_is_read), .cmd_bank(cmd_bank), .cmd_addr(cmd_addr),
        .cmd_data(cmd_data), .cfg_wait(cfg_wait), .cfg_hold(cfg_hold),
        .cfg_ack_en(cfg_ack_en), .mem_ack(mem_ack), .mem_sel_n(mem_sel_n),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_wdata_oe(mem_wdata_oe),
        .mem_wr_n(mem_wr_n), .mem_rd_n(mem_rd_n));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
        end
    endtask

    task automatic check_idle(input string req);
        chk(mem_wr_n && mem_rd_n, {req, " strobes high"}, {mem_wr_n, mem_rd_n}, 3);
        chk(mem_sel_n == '1, {req, " selects high"}, int'(mem_sel_n), 15);
        chk(!mem_wdata_oe, {req, " data released"}, mem_wdata_oe, 0);
        chk(cmd_ready, {req, " ready"}, cmd_ready, 1);
    endtask

    // Driver: present a command, wait for acceptance, queue the expectation
    task automatic send(input bit rd, input int bank, input int addr, input int data,
                        input int w, input int h, input bit ack_en, input int stretch);
        exp_t e;
        int weff;
        weff = (w == 0) ? 1 : w;
        e.rd = rd; e.bank = bank; e.addr = ADDR_W'(addr); e.data = DATA_W'(data);
        e.low = (ack_en ? weff + stretch : weff);
        e.setup = rd ? 0 : 1 + e.low;
        e.hold = h;
        e.gap = prev_wr ? (rd ? prev_h + 3 : prev_h + 2) : -1;
        e.stretch = stretch;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_is_read = rd; cmd_bank = BANK_W'(bank);
        cmd_addr = e.addr; cmd_data = e.data;
        cfg_wait = CNT_W'(w); cfg_hold = CNT_W'(h);
        while (!cmd_ready) @(negedge clk);
        @(posedge clk);
        q.push_back(e);
        #1;
        cmd_valid = 1'b0;
        cfg_ack_en = ack_en;
        // R11: scramble counts after acceptance
        cfg_wait = ~CNT_W'(w); cfg_hold = ~CNT_W'(h);
        @(negedge clk);
        chk(!cmd_ready, "R12 ready low after accept", cmd_ready, 0);
        prev_wr = !rd; prev_h = h;
    endtask

    // Acknowledge responder: pulls ack low for the stretch of the current access
    initial begin
        bit pst = 0;
        forever begin
            @(negedge clk);
            if (mon_en && (!mem_wr_n || !mem_rd_n) && !pst && q.size() > 0 && q[0].stretch > 0) begin
                mem_ack = 1'b0;
                repeat (q[0].stretch) @(negedge clk);
                mem_ack = 1'b1;
                pst = 1;
            end else begin
                pst = !mem_wr_n || !mem_rd_n;
            end
        end
    end

    // Monitor: measure each access and compare with the queued expectation
    initial begin
        bit p_strobe = 0, p_sel = 0, pp_sel = 0, in_hold = 0, cur_rd = 0, sel_ok = 0;
        int oe_run = 0, oe_low = 0, setup_len = 0, fall_c = 0, rise_c = 0, low_len = 0;
        int last_wr_rise = -1, gap = -1, cbank = -1, oe_low_at_fall = 0;
        logic [ADDR_W-1:0] caddr;
        logic [DATA_W-1:0] cdata;
        forever begin
            bit strobe, sel;
            @(negedge clk);
            if (!mon_en) continue;
            strobe = !mem_wr_n || !mem_rd_n;
            sel = (mem_sel_n != '1);
            if (strobe && !p_strobe) begin
                fall_c = cyc; cur_rd = !mem_rd_n;
                caddr = mem_addr; cdata = mem_wdata;
                cbank = -1;
                for (int b = 0; b < NBANK; b++) if (!mem_sel_n[b]) cbank = b;
                sel_ok = p_sel && !pp_sel;
                gap = (last_wr_rise >= 0) ? cyc - last_wr_rise : -1;
                oe_low_at_fall = oe_low;
            end
            oe_run = mem_wdata_oe ? oe_run + 1 : 0;
            oe_low = mem_wdata_oe ? 0 : oe_low + 1;
            if (strobe) setup_len = oe_run;
            if (!strobe && p_strobe) begin
                low_len = cyc - fall_c; rise_c = cyc; in_hold = 1;
                if (!cur_rd) last_wr_rise = cyc;
            end
            if (in_hold && sel) begin
                chk(mem_addr == caddr, "R5 address held", int'(mem_addr), int'(caddr));
                if (!cur_rd) chk(mem_wdata_oe && mem_wdata == cdata, "R5 data held",
                                 int'(mem_wdata), int'(cdata));
            end
            if (in_hold && !sel) begin
                exp_t e;
                in_hold = 0;
                if (q.size() == 0) begin
                    chk(0, "R2 unexpected access", 1, 0);
                end else begin
                    e = q.pop_front();
                    chk(cur_rd == e.rd, "R2 strobe kind", cur_rd, e.rd);
                    chk(cbank == e.bank, "R2 bank select", cbank, e.bank);
                    chk(sel_ok, "R2 select one clock before strobe", sel_ok, 1);
                    chk(caddr == e.addr, "R2 address", int'(caddr), int'(e.addr));
                    if (!e.rd) chk(cdata == e.data, "R2 write data", int'(cdata), int'(e.data));
                    chk(low_len == e.low, "R3 R9 R10 R11 strobe width", low_len, e.low);
                    chk(setup_len == e.setup, "R4 data setup", setup_len, e.setup);
                    chk(cyc - rise_c == e.hold, "R5 hold length", cyc - rise_c, e.hold);
                    chk(!mem_wdata_oe, "R5 data released with select", mem_wdata_oe, 0);
                    chk(cmd_ready, "R12 ready after hold", cmd_ready, 1);
                    if (e.gap >= 0)
                        chk(gap == e.gap, e.rd ? "R7 write-to-read gap" : "R6 write-to-write gap",
                            gap, e.gap);
                    if (e.rd) chk(oe_low_at_fall >= 2, "R8 bus released before read",
                                  oe_low_at_fall, 2);
                end
            end
            pp_sel = p_sel; p_sel = sel; p_strobe = strobe;
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Stimulus
    initial begin
        repeat (3) @(negedge clk);
        check_idle("R1 during reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("R1 after reset");
        send(0, 1, 16'h1234, 16'hA5A5, 3, 2, 0, 0);
        send(0, 2, 16'h0042, 16'h5A5A, 1, 0, 0, 0);     // R6 gap 4
        send(0, 3, 16'h0777, 16'h0F0F, 0, 1, 0, 0);     // R3 zero wait, R6 gap 2
        send(1, 0, 16'h0100, 16'h0000, 2, 1, 0, 0);     // R7 gap 4, R8
        send(0, 0, 16'h0200, 16'hBEEF, 2, 3, 1, 3);     // R9 stretch 3
        send(1, 1, 16'h0300, 16'h0000, 4, 0, 1, 2);     // R7 gap 6, R9 read stretch
        send(0, 1, 16'h0400, 16'hCAFE, 2, 2, 0, 4);     // R10 ack ignored
        send(0, 2, 16'hFFFF, 16'h1357, 31, 31, 0, 0);   // R6 gap 4, extremes
        send(1, 3, 16'h8000, 16'h0000, 1, 2, 0, 0);     // R7 gap 34
        repeat (60) @(negedge clk);
        chk(q.size() == 0, "R2 all accesses seen", q.size(), 0);
        // R1: reset in the middle of a write strobe
        mon_en = 0;
        @(negedge clk);
        cmd_valid = 1; cmd_is_read = 0; cfg_wait = 5'd10; cfg_hold = 5'd2; cfg_ack_en = 0;
        while (mem_wr_n) @(negedge clk);
        cmd_valid = 0;
        rst_n = 1'b0;
        @(negedge clk);
        check_idle("R1 reset mid-access");
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("R1 after mid-access reset");
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule